// File: doc/BRIEF.md
# Register Ready-Cycle Latency Tracker

This block keeps a small scoreboard of data latency for a program scheduler. Each of eight registers has one entry: the cycle at which its newest value becomes readable. When the scheduler commits an instruction, it strobes a write plan carrying the destination register, the cycle the instruction issues on and the operation code. The block then stores the issue cycle plus that operation's latency, replacing whatever the register held before.

Two results are read from the block. The first answers a query: given a register and a cycle, is the register's value ready by then? The second is the overall latency of the program so far, which is the latest ready cycle among all registers. The scheduler uses the query to pick operands that avoid stalls, and uses the overall latency to measure the finished program. An instruction without a destination register sets a flag that suppresses the write.

Top module: `reg_ready_tracker`

## Requirements
- R1: After reset every stored ready cycle is 0 and `overall_lat` is 0, so any register queried at cycle 0 reports available.
- R2: Operation codes 0 to 7 (add-const, add-shift, branch, rotate, sub, target, xor, xor-const) have a latency of 1 cycle.
- R3: Code 8 (multiply) has a latency of 3. Codes 9 (signed high-multiply) and 10 (unsigned high-multiply) have a latency of 4. The unused codes 11 to 15 take 1.
- R4: An accepted write stores `wr_cycle` plus the latency in entry `wr_reg` at the next rising clock edge. It overwrites the old value, even when the new value is lower.
- R5: A write is accepted only when `wr_en` is 1 and `wr_no_dst` is 0. In every other case the stored entries do not change.
- R6: `q_avail` is combinational and equals 1 exactly when the stored ready cycle of `q_reg` is less than or equal to `q_cycle`.
- R7: `overall_lat` is a register. It holds the maximum of all stored ready cycles and changes at the same edge that stores a write. It falls when the register holding the maximum is overwritten with a smaller value.
- R8: Ready cycles are CW bits wide (8 by default). A sum that would exceed 2^CW-1 saturates at 2^CW-1 (255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write-plan strobe |
| wr_no_dst | input | 1 | Instruction has no destination; suppresses the write |
| wr_reg | input | 3 | Destination register ID |
| wr_cycle | input | 8 | Issue cycle |
| wr_op | input | 4 | Operation code |
| q_reg | input | 3 | Register to query |
| q_cycle | input | 8 | Cycle to test availability at |
| q_avail | output | 1 | Register ready by q_cycle |
| overall_lat | output | 8 | Maximum ready cycle over all registers |

## Verification
The bench builds the tracker with its default values: eight registers, 8-bit cycles and 4-bit operation codes. With this 8-bit width, issue cycles close to 255 can be driven, so saturation and the largest normal ready cycle of 195 are both exercised. Because there are only eight registers, the bench can hold the whole state in its own model. Queries then sit exactly on each side of every ready cycle, and lowering the entry that holds the maximum shows that the overall latency falls again.

// File: rtl/reg_ready_tracker.sv
module reg_ready_tracker #(
  parameter int NREG = 8,
  parameter int CW   = 8,
  parameter int OPW  = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_no_dst,
  input  logic [RW-1:0] wr_reg,
  input  logic [CW-1:0] wr_cycle,
  input  logic [OPW-1:0] wr_op,
  input  logic [RW-1:0] q_reg,
  input  logic [CW-1:0] q_cycle,
  output logic          q_avail,
  output logic [CW-1:0] overall_lat
);
  localparam logic [CW:0] SAT = {1'b0, {CW{1'b1}}};

  logic [NREG-1:0][CW-1:0] ready, ready_nxt;
  logic [CW-1:0] lat, sum_sat, max_nxt;
  logic [CW:0]   sum;
  logic          accept;

  always_comb begin
    case (wr_op)
      OPW'(8):           lat = CW'(3);
      OPW'(9), OPW'(10): lat = CW'(4);
      default:           lat = CW'(1);
    endcase
  end

  assign accept  = wr_en && !wr_no_dst;
  assign sum     = {1'b0, wr_cycle} + {1'b0, lat};
  assign sum_sat = (sum > SAT) ? {CW{1'b1}} : sum[CW-1:0];

  always_comb begin
    ready_nxt = ready;
    if (accept) ready_nxt[wr_reg] = sum_sat;
  end

  always_comb begin
    max_nxt = '0;
    for (int i = 0; i < NREG; i++)
      if (ready_nxt[i] > max_nxt) max_nxt = ready_nxt[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready       <= '0;
      overall_lat <= '0;
    end else begin
      ready       <= ready_nxt;
      overall_lat <= max_nxt;
    end
  end

  assign q_avail = ready[q_reg] <= q_cycle;
endmodule

module reg_ready_tracker_chk #(
  parameter int NREG = 8,
  parameter int CW   = 8,
  parameter int OPW  = 4,
  parameter int RW   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    wr_no_dst,
  input logic [RW-1:0]           wr_reg,
  input logic [CW-1:0]           wr_cycle,
  input logic [OPW-1:0]          wr_op,
  input logic [RW-1:0]           q_reg,
  input logic [CW-1:0]           q_cycle,
  input logic                    q_avail,
  input logic [CW-1:0]           overall_lat,
  input logic [NREG-1:0][CW-1:0] ready
);
  p_mul_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_no_dst && wr_op == OPW'(8) && wr_cycle < CW'(200))
    |=> ready[$past(wr_reg)] == CW'($past(wr_cycle) + CW'(3)));

  p_nodst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_no_dst || !wr_en) |=> $stable(ready));

  p_overall_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overall_lat >= ready[q_reg]);

  p_avail_past_overall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cycle >= overall_lat) |-> q_avail);

  p_write_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_no_dst) |=> ready[$past(wr_reg)] > $past(wr_cycle) ||
                              ready[$past(wr_reg)] == {CW{1'b1}});
endmodule

bind reg_ready_tracker reg_ready_tracker_chk #(
  .NREG(NREG), .CW(CW), .OPW(OPW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_no_dst(wr_no_dst),
  .wr_reg(wr_reg), .wr_cycle(wr_cycle), .wr_op(wr_op), .q_reg(q_reg),
  .q_cycle(q_cycle), .q_avail(q_avail), .overall_lat(overall_lat),
  .ready(ready)
);

// File: tb/tb_reg_ready_tracker.sv
module tb_reg_ready_tracker;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [2:0] rg;
    logic [7:0] cyc;
    logic       avail;
    logic [7:0] ovl;
    string      tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_no_dst = 0;
  logic [2:0] wr_reg = 0, q_reg = 0;
  logic [7:0] wr_cycle = 0, q_cycle = 0;
  logic [3:0] wr_op = 0;
  logic q_avail;
  logic [7:0] overall_lat;

  int checks = 0, failures = 0;
  logic [7:0] model [8];
  exp_t sb [$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_ready_tracker dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_no_dst(wr_no_dst),
    .wr_reg(wr_reg), .wr_cycle(wr_cycle), .wr_op(wr_op), .q_reg(q_reg),
    .q_cycle(q_cycle), .q_avail(q_avail), .overall_lat(overall_lat)
  );

  function automatic int lat_of(input logic [3:0] op);
    if (op == 4'd8) return 3;
    if (op == 4'd9 || op == 4'd10) return 4;
    return 1;
  endfunction

  function automatic logic [7:0] model_max();
    logic [7:0] m = 0;
    for (int i = 0; i < 8; i++) if (model[i] > m) m = model[i];
    return m;
  endfunction

  task automatic do_write(input logic [2:0] r, input logic [7:0] c,
                          input logic [3:0] op, input logic en, input logic nd);
    int s;
    @(posedge clk); #1;
    wr_en = en; wr_no_dst = nd; wr_reg = r; wr_cycle = c; wr_op = op;
    @(posedge clk); #1;
    wr_en = 0; wr_no_dst = 0;
    if (en && !nd) begin
      s = int'(c) + lat_of(op);
      model[r] = (s > 255) ? 8'd255 : 8'(s);
    end
  endtask

  task automatic query(input logic [2:0] r, input logic [7:0] c, input string tag);
    exp_t e;
    @(posedge clk); #1;
    q_reg = r; q_cycle = c;
    e.rg = r; e.cyc = c; e.avail = (model[r] <= c); e.ovl = model_max(); e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        e = sb.pop_front();
        checks++;
        if (q_avail !== e.avail) begin
          failures++;
          $display("FAIL %s avail reg%0d@%0d: actual=%0b expected=%0b",
                   e.tag, e.rg, e.cyc, q_avail, e.avail);
        end
        checks++;
        if (overall_lat !== e.ovl) begin
          failures++;
          $display("FAIL %s overall: actual=%0d expected=%0d", e.tag, overall_lat, e.ovl);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    query(3'd0, 8'd0, "R1");
    query(3'd7, 8'd0, "R1");
    do_write(3'd1, 8'd10, 4'd0, 1, 0);
    query(3'd1, 8'd10, "R6");
    query(3'd1, 8'd11, "R4");
    for (int op = 0; op < 8; op++) begin
      do_write(3'd2, 8'd20, 4'(op), 1, 0);
      query(3'd2, 8'd20, "R2");
      query(3'd2, 8'd21, "R2");
    end
    do_write(3'd3, 8'd30, 4'd8, 1, 0);
    query(3'd3, 8'd32, "R3");
    query(3'd3, 8'd33, "R3");
    do_write(3'd4, 8'd40, 4'd9, 1, 0);
    query(3'd4, 8'd43, "R3");
    query(3'd4, 8'd44, "R3");
    do_write(3'd5, 8'd50, 4'd10, 1, 0);
    query(3'd5, 8'd53, "R3");
    query(3'd5, 8'd54, "R7");
    do_write(3'd6, 8'd60, 4'd12, 1, 0);
    query(3'd6, 8'd60, "R3");
    query(3'd6, 8'd61, "R7");
    do_write(3'd6, 8'd5, 4'd0, 1, 0);
    query(3'd6, 8'd6, "R4");
    query(3'd6, 8'd5, "R7");
    do_write(3'd0, 8'd100, 4'd9, 1, 1);
    query(3'd0, 8'd0, "R5");
    do_write(3'd1, 8'd120, 4'd8, 0, 0);
    query(3'd1, 8'd11, "R5");
    do_write(3'd0, 8'd191, 4'd10, 1, 0);
    query(3'd0, 8'd194, "R7");
    query(3'd0, 8'd195, "R7");
    do_write(3'd7, 8'd254, 4'd10, 1, 0);
    query(3'd7, 8'd254, "R8");
    query(3'd7, 8'd255, "R8");
    for (int r = 0; r < 8; r++) query(3'(r), 8'd255, "R6");
    repeat (4) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule